// File: doc/BRIEF.md
# Bank Timing Guard

This block watches every command issued to a single DRAM bank and works out, one cycle at a time, which command types that bank may legally accept next. The command arrives as a 4-bit code, together with a flag that gives the burst length of reads and writes (16 or 32). The block then drives a 9-bit vector with one permission bit per command type. A scheduler ANDs this vector with its other constraints (bank-to-bank spacing, rank spacing, bus arbitration) before it picks a command. Those other constraints are handled elsewhere.

Every minimum spacing is a parameter counted in clock cycles. Internally the block keeps four spacing counters:
- one for column commands;
- one for precharge;
- one for activate;
- one for refresh.

Each issued command may raise one or more of these counters. A counter is never lowered by a later command that needs a shorter wait. Because the spacing after a read or write depends on that access's own burst length, the flag is captured together with the command. Auto-precharge accesses also fold the precharge recovery time into the activate wait.

Command codes: 0 idle, 1 activate, 2 read, 3 write, 4 read with auto-precharge, 5 write with auto-precharge, 6 single-bank precharge, 7 all-bank precharge, 8 single-bank refresh, 9 all-bank refresh, 10 to 15 unused.

Permission bits: bit 0 activate, bit 1 read, bit 2 write, bit 3 read-AP, bit 4 write-AP, bit 5 single-bank precharge, bit 6 all-bank precharge, bit 7 single-bank refresh, bit 8 all-bank refresh.

"Gap N after X" means the following:
- X is presented in cycle t.
- The affected bits read 0 in cycles t+1 through t+N-1.
- The bits return to 1 in cycle t+N, unless some other wait still holds them.
- A command never changes the permission bits in the same cycle it is presented.

BL is T_BL16 when the access had the flag clear, and T_BL32 when the flag was set.

Top module: `bank_timing_guard`

## Requirements
- R1: After reset is released, all nine permission bits are 1.
- R2: After an activate, bits 1 to 4 (read, write, read-AP, write-AP) have gap T_RCD+1.
- R3: After an activate, bits 5 and 6 (both precharges) have gap T_RAS+1.
- R4: After a read or read-AP, bits 5 and 6 have gap BL+T_RBTP, where BL follows that access's burst-length flag.
- R5: After a write or write-AP, bits 5 and 6 have gap T_WL+BL+1+T_WR.
- R6: Bit 0 (activate) has gap T_RC after an activate and gap T_RP-1 after a single-bank precharge.
- R7: Bit 0 has gap BL+T_RBTP+T_RP-1 after a read-AP and gap T_WL+BL+T_WR+T_RP after a write-AP.
- R8: After a single-bank refresh, bit 0 has gap T_RFC-1 and bits 7 and 8 have gap T_RFC.
- R9: Bit 0 has gap T_RPAB-1 after an all-bank precharge and gap T_RFCAB-1 after an all-bank refresh.
- R10: For the command codes 1, 4, 5, 6, 7, 8 and 9, bits 7 and 8 (refresh) have a gap one cycle longer than bit 0 has after the same command. The exception is that code 9 gives them gap T_RFCAB.
- R11: A command that needs a shorter wait never shortens a wait that is still running; each bit returns to 1 only once the longest outstanding gap has elapsed.
- R12: Codes 0 and 10 to 15 change no permission bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 4 | Command issued to the bank this cycle |
| bl32_i | input | 1 | Burst length of this cycle's access: 1 for 32, 0 for 16 |
| allow_o | output | 9 | Per-command permission bits for the current cycle |

## Verification
A command presented in cycle t passes through one register stage. Its earliest effect is therefore on the permission bits in cycle t+1, and a wait of gap N releases the bit in cycle t+N.

The bench drives inputs and samples allow_o at the falling edge. It keeps a ready cycle for each counter, computed as the issue cycle plus the gap given in the requirements. Every bit is compared on every cycle against whether the current cycle has reached its counter's ready cycle.

Directed probes add the edge cases. They check that each gap's bit is still 0 exactly one cycle before the due cycle and 1 exactly on it. They also cover a shorter wait arriving under a longer one.

// File: rtl/btg_pkg.sv
package btg_pkg;

   typedef enum logic [3:0] {
      CMD_IDLE   = 4'd0,
      CMD_OPEN   = 4'd1,
      CMD_RD     = 4'd2,
      CMD_WR     = 4'd3,
      CMD_RDAP   = 4'd4,
      CMD_WRAP   = 4'd5,
      CMD_PCH    = 4'd6,
      CMD_PCHALL = 4'd7,
      CMD_RFB    = 4'd8,
      CMD_RFALL  = 4'd9
   } btg_cmd_e;

   // spacing counters, one per group of gated commands
   localparam int NGATE     = 4;
   localparam int GATE_COL  = 0;
   localparam int GATE_PCH  = 1;
   localparam int GATE_OPEN = 2;
   localparam int GATE_RFB  = 3;

   localparam int NALLOW = 9;

endpackage

// File: rtl/btg_gap_counter.sv
module btg_gap_counter #(
   parameter int CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] load_i,
   output logic          idle_o
);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] dec;

   assign dec    = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
   assign idle_o = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= (load_i > dec) ? load_i : dec;
   end

   // R11: a new requirement is always honoured in full
   p_load_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i != '0) |=> (cnt_q >= $past(load_i)));

   // R11: without a new requirement the wait only shrinks
   p_no_growth_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i == '0) |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/btg_load_decode.sv
module btg_load_decode
   import btg_pkg::*;
#(
   parameter int CW      = 6,
   parameter int T_RCD   = 4,
   parameter int T_RAS   = 9,
   parameter int T_RC    = 12,
   parameter int T_RP    = 4,
   parameter int T_RPAB  = 5,
   parameter int T_RBTP  = 2,
   parameter int T_WL    = 3,
   parameter int T_WR    = 5,
   parameter int T_RFC   = 14,
   parameter int T_RFCAB = 20,
   parameter int T_BL16  = 2,
   parameter int T_BL32  = 4
) (
   input  logic [3:0]                 cmd_i,
   input  logic                       bl32_i,
   output logic [NGATE-1:0][CW-1:0]   load_o
);

   int blm;
   int gap [NGATE];

   always_comb begin
      blm = bl32_i ? T_BL32 : T_BL16;
      for (int i = 0; i < NGATE; i++) gap[i] = 0;
      case (btg_cmd_e'(cmd_i))
         CMD_OPEN: begin
            gap[GATE_COL]  = T_RCD + 1;
            gap[GATE_PCH]  = T_RAS + 1;
            gap[GATE_OPEN] = T_RC;
            gap[GATE_RFB]  = T_RC + 1;
         end
         CMD_RD: gap[GATE_PCH] = blm + T_RBTP;
         CMD_WR: gap[GATE_PCH] = T_WL + blm + 1 + T_WR;
         CMD_RDAP: begin
            gap[GATE_PCH]  = blm + T_RBTP;
            gap[GATE_OPEN] = blm + T_RBTP + T_RP - 1;
            gap[GATE_RFB]  = blm + T_RBTP + T_RP;
         end
         CMD_WRAP: begin
            gap[GATE_PCH]  = T_WL + blm + 1 + T_WR;
            gap[GATE_OPEN] = T_WL + blm + T_WR + T_RP;
            gap[GATE_RFB]  = T_WL + blm + 1 + T_WR + T_RP;
         end
         CMD_PCH: begin
            gap[GATE_OPEN] = T_RP - 1;
            gap[GATE_RFB]  = T_RP;
         end
         CMD_PCHALL: begin
            gap[GATE_OPEN] = T_RPAB - 1;
            gap[GATE_RFB]  = T_RPAB;
         end
         CMD_RFB: begin
            gap[GATE_OPEN] = T_RFC - 1;
            gap[GATE_RFB]  = T_RFC;
         end
         CMD_RFALL: begin
            gap[GATE_OPEN] = T_RFCAB - 1;
            gap[GATE_RFB]  = T_RFCAB;
         end
         default: ;
      endcase
      // a gap of N cycles is held as N-1 counts after the issuing edge
      for (int i = 0; i < NGATE; i++)
         load_o[i] = (gap[i] > 0) ? CW'(gap[i] - 1) : '0;
   end

endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
   import btg_pkg::*;
#(
   parameter int T_RCD   = 4,
   parameter int T_RAS   = 9,
   parameter int T_RC    = 12,
   parameter int T_RP    = 4,
   parameter int T_RPAB  = 5,
   parameter int T_RBTP  = 2,
   parameter int T_WL    = 3,
   parameter int T_WR    = 5,
   parameter int T_RFC   = 14,
   parameter int T_RFCAB = 20,
   parameter int T_BL16  = 2,
   parameter int T_BL32  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       cmd_i,
   input  logic             bl32_i,
   output logic [NALLOW-1:0] allow_o
);

   localparam int SPAN = T_RFCAB + T_RFC + T_RC + T_RAS + T_RCD + T_RPAB + T_RP
                       + T_WL + T_WR + T_RBTP + T_BL32 + T_BL16 + 2;
   localparam int CW   = $clog2(SPAN + 1);

   // elaboration-time parameter checks: every gap must be at least 2
   if (T_RP < 3 || T_RPAB < 3 || T_RFC < 3 || T_RFCAB < 3) begin : g_bad_recovery
      $error("bank_timing_guard: recovery parameters must be at least 3");
   end
   if (T_RCD < 1 || T_RAS < 1 || T_RC < 2 || T_RBTP < 0 || T_WL < 0 || T_WR < 0)
   begin : g_bad_core
      $error("bank_timing_guard: core spacing parameters out of range");
   end
   if (T_BL16 < 1 || T_BL32 < T_BL16) begin : g_bad_burst
      $error("bank_timing_guard: burst durations out of range");
   end

   logic [NGATE-1:0][CW-1:0] load;
   logic [NGATE-1:0]         idle;

   btg_load_decode #(
      .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
      .T_RPAB(T_RPAB), .T_RBTP(T_RBTP), .T_WL(T_WL), .T_WR(T_WR),
      .T_RFC(T_RFC), .T_RFCAB(T_RFCAB), .T_BL16(T_BL16), .T_BL32(T_BL32)
   ) u_decode (
      .cmd_i  (cmd_i),
      .bl32_i (bl32_i),
      .load_o (load)
   );

   for (genvar g = 0; g < NGATE; g++) begin : g_gate
      btg_gap_counter #(.CW(CW)) u_cnt (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_i (load[g]),
         .idle_o (idle[g])
      );
   end

   assign allow_o[0] = idle[GATE_OPEN];
   assign allow_o[1] = idle[GATE_COL];
   assign allow_o[2] = idle[GATE_COL];
   assign allow_o[3] = idle[GATE_COL];
   assign allow_o[4] = idle[GATE_COL];
   assign allow_o[5] = idle[GATE_PCH];
   assign allow_o[6] = idle[GATE_PCH];
   assign allow_o[7] = idle[GATE_RFB];
   assign allow_o[8] = idle[GATE_RFB];

   // R1: first cycle after reset leaves everything open
   p_open_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (&allow_o));

   // R2: column commands blocked right after an activate
   p_col_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_OPEN) |=> (allow_o[4:1] == 4'b0000));

   // R3: precharges blocked right after an activate
   p_pch_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_OPEN) |=> (allow_o[6:5] == 2'b00));

   // R6: back-to-back activates are never permitted
   p_open_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_OPEN) |=> !allow_o[0]);

   // R9: all-bank refresh closes the activate window
   p_rfall_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_RFALL) |=> !allow_o[0]);

   // R10: refresh never opens before activate does
   p_rfb_after_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
      allow_o[7] |-> allow_o[0]);

   // R12: idle and unused codes leave a fully open bank open
   p_ignore_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_i == 4'd0 || cmd_i > 4'd9) && (&allow_o)) |=> (&allow_o));

endmodule

// File: tb/tb_bank_timing_guard.sv
`timescale 1ns/1ps
module tb_bank_timing_guard;

   localparam int P_RCD = 4, P_RAS = 9, P_RC = 12, P_RP = 4, P_RPAB = 5;
   localparam int P_RBTP = 2, P_WL = 3, P_WR = 5, P_RFC = 14, P_RFCAB = 20;
   localparam int P_BL16 = 2, P_BL32 = 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] cmd_i;
   logic       bl32_i;
   logic [8:0] allow_o;

   always #5 clk = ~clk;

   bank_timing_guard #(
      .T_RCD(P_RCD), .T_RAS(P_RAS), .T_RC(P_RC), .T_RP(P_RP), .T_RPAB(P_RPAB),
      .T_RBTP(P_RBTP), .T_WL(P_WL), .T_WR(P_WR), .T_RFC(P_RFC),
      .T_RFCAB(P_RFCAB), .T_BL16(P_BL16), .T_BL32(P_BL32)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bl32_i(bl32_i), .allow_o(allow_o)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int ready [4];

   // gates: 0 column, 1 precharge, 2 activate, 3 refresh
   function automatic int gap(int g, int code, logic bl);
      int b;
      b = bl ? P_BL32 : P_BL16;
      gap = 0;
      case (g)
         0: if (code == 1) gap = P_RCD + 1;
         1: case (code)
               1:    gap = P_RAS + 1;
               2, 4: gap = b + P_RBTP;
               3, 5: gap = P_WL + b + 1 + P_WR;
               default: gap = 0;
            endcase
         2: case (code)
               1: gap = P_RC;
               4: gap = b + P_RBTP + P_RP - 1;
               5: gap = P_WL + b + P_WR + P_RP;
               6: gap = P_RP - 1;
               7: gap = P_RPAB - 1;
               8: gap = P_RFC - 1;
               9: gap = P_RFCAB - 1;
               default: gap = 0;
            endcase
         default: case (code)
               1: gap = P_RC + 1;
               4: gap = b + P_RBTP + P_RP;
               5: gap = P_WL + b + P_WR + P_RP + 1;
               6: gap = P_RP;
               7: gap = P_RPAB;
               8: gap = P_RFC;
               9: gap = P_RFCAB;
               default: gap = 0;
            endcase
      endcase
   endfunction

   function automatic int gate_of(int b);
      if (b == 0) return 2;
      if (b <= 4) return 0;
      if (b <= 6) return 1;
      return 3;
   endfunction

   function automatic string tag_of(int g);
      case (g)
         0:       return "R2";
         1:       return "R3,R4,R5";
         2:       return "R6,R7,R9,R11";
         default: return "R8,R10";
      endcase
   endfunction

   task automatic compare_all();
      for (int b = 0; b < 9; b++) begin
         logic e;
         e = (cyc >= ready[gate_of(b)]);
         checks++;
         if (allow_o[b] !== e) begin
            fails++;
            $display("FAIL %s bit %0d cycle %0d: actual %b expected %b",
                     tag_of(gate_of(b)), b, cyc, allow_o[b], e);
         end
      end
   endtask

   task automatic named(string tag, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s cycle %0d: actual %b expected %b", tag, cyc, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(int code, logic bl);
      compare_all();
      cmd_i  = 4'(code);
      bl32_i = bl;
      for (int g = 0; g < 4; g++) begin
         int n;
         n = gap(g, code, bl);
         if (n > 0 && cyc + n > ready[g]) ready[g] = cyc + n;
      end
      @(posedge clk);
      cyc++;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 1'b0);
   endtask

   // issue code, check bit b is 0 one cycle before gap n and 1 at gap n
   task automatic probe(int code, logic bl, int b, int n, string tag);
      idle(25);
      step(code, bl);
      for (int i = 0; i < n - 2; i++) step(0, 1'b0);
      named(tag, allow_o[b], 1'b0);
      step(0, 1'b0);
      named(tag, allow_o[b], 1'b1);
   endtask

   initial begin
      #1_500_000;
      fails++;
      $display("FAIL watchdog: actual run still busy, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int g = 0; g < 4; g++) ready[g] = 0;
      rst_n  = 1'b0;
      cmd_i  = 4'd0;
      bl32_i = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      named("R1", &allow_o, 1'b1);

      // directed gap probes
      probe(1, 1'b0, 1, P_RCD + 1, "R2");
      probe(1, 1'b0, 5, P_RAS + 1, "R3");
      probe(2, 1'b0, 5, P_BL16 + P_RBTP, "R4");
      probe(2, 1'b1, 6, P_BL32 + P_RBTP, "R4");
      probe(3, 1'b1, 5, P_WL + P_BL32 + 1 + P_WR, "R5");
      probe(1, 1'b0, 0, P_RC, "R6");
      probe(6, 1'b0, 0, P_RP - 1, "R6");
      probe(4, 1'b1, 0, P_BL32 + P_RBTP + P_RP - 1, "R7");
      probe(5, 1'b0, 0, P_WL + P_BL16 + P_WR + P_RP, "R7");
      probe(8, 1'b0, 0, P_RFC - 1, "R8");
      probe(8, 1'b0, 7, P_RFC, "R8");
      probe(7, 1'b0, 0, P_RPAB - 1, "R9");
      probe(9, 1'b0, 0, P_RFCAB - 1, "R9");
      probe(1, 1'b0, 8, P_RC + 1, "R10");
      probe(9, 1'b0, 7, P_RFCAB, "R10");

      // R11: a precharge under a running activate wait does not shorten it
      idle(25);
      step(1, 1'b0);
      step(0, 1'b0);
      step(6, 1'b0);
      for (int i = 0; i < P_RC - 4; i++) step(0, 1'b0);
      named("R11", allow_o[0], 1'b0);
      step(0, 1'b0);
      named("R11", allow_o[0], 1'b1);

      // R12: idle and unused codes change nothing
      idle(25);
      step(13, 1'b1);
      named("R12", &allow_o, 1'b1);
      step(0, 1'b1);
      named("R12", &allow_o, 1'b1);

      // sweep every code with both burst lengths
      for (int c = 0; c < 16; c++)
         for (int bl = 0; bl < 2; bl++) begin
            step(c, bl[0]);
            idle(26);
         end

      // sweep command pairs at short separations
      for (int c1 = 1; c1 < 10; c1++)
         for (int c2 = 1; c2 < 10; c2++)
            for (int bl = 0; bl < 2; bl++)
               for (int d = 0; d < 4; d++) begin
                  step(c1, bl[0]);
                  idle(d);
                  step(c2, ~bl[0]);
                  idle(26);
               end

      // random traffic
      for (int i = 0; i < 5000; i++) begin
         if ($urandom_range(0, 2) == 0) step(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
         else                           step(0, 1'b0);
      end
      compare_all();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule